// File: doc/BRIEF.md
# JTAG Test Access Port with Device Control Instructions

This block is a boundary-scan test access port controller for one device in a JTAG chain. It runs the standard sixteen-state controller on TMS, holds a 10-bit instruction, and places one of three data registers between TDI and TDO: a 32-bit user code loaded from a parallel input, a 32-bit identification constant, or a single bypass bit. TMS and TDI are sampled on the rising edge of TCK. TDO changes on the falling edge and is qualified by an enable that is high only while a register is being shifted.

Some instructions also drive device-level control outputs. One floats every I/O pin. One freezes the pins at a boundary-scan word that is taken from a parallel input. One asks the device to reconfigure by means of a single-cycle pulse. One pulls a configuration status line low and keeps it low until reconfiguration, and it also aborts a configuration that is running. The boundary-scan chain itself and the configuration engine are outside this block. It is used as the test port of a larger chip, driven by an external JTAG probe.

Top module: `jtag_dev_tap`

## Requirements
- R1: When trst_n is low at a rising TCK edge, the controller enters Test-Logic-Reset and the active instruction becomes the identification code 0x006. After that, pins_hiz, pins_clamp, reconfig_pulse, cfg_abort and tdo_en are 0 and cfg_status_n is 1.
- R2: In Capture-IR the instruction shift register loads 10'b00_0000_0001. In Shift-IR it shifts toward the LSB: bit 0 appears first on TDO and TDI enters at bit 9.
- R3: When the active instruction is 0x007, Capture-DR loads usercode_i into a 32-bit register, which Shift-DR moves out on TDO LSB first while TDI enters at bit 31.
- R4: When the active instruction is 0x006, Capture-DR loads the IDCODE_VAL parameter, which shifts out in the same way as in R3.
- R5: Every other instruction code selects the 1-bit bypass register. It captures 0, so a DR scan returns 0 followed by TDI delayed by one bit.
- R6: pins_hiz is 1 exactly while the active instruction is 0x00B, and that instruction uses the bypass register.
- R7: pins_clamp is 1 exactly while the active instruction is 0x00A. clamp_val takes bscan_i at the Update-IR edge that loads 0x00A and then keeps that value however bscan_i changes.
- R8: While 0x001 is active, each entry into Run-Test/Idle from another state raises reconfig_pulse for exactly one TCK cycle. Staying in Run-Test/Idle gives no further pulse.
- R9: An Update-IR of 0x00D drives cfg_status_n low. It stays low while other instructions are loaded, and it returns high only in the cycle of a reconfiguration pulse or on trst_n.
- R10: An Update-IR of 0x00D while cfg_busy_i is 1 gives a one-cycle cfg_abort pulse. If cfg_busy_i is 0, no pulse is given.
- R11: Five consecutive rising edges with TMS high put the controller in Test-Logic-Reset from any state, which reloads instruction 0x006.
- R12: tdo_en is 1 only in Shift-IR and Shift-DR, and it is updated on the falling TCK edge together with tdo. tdo is 0 while tdo_en is 0.
- R13: A newly shifted instruction has no effect until the Update-IR edge. Its outputs change in the cycle after Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising TCK |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for tdo (shift states only) |
| usercode_i | input | 32 | Value captured by the user code instruction |
| bscan_i | input | PIN_W | Parallel boundary-scan word used for clamping |
| cfg_busy_i | input | 1 | Configuration currently in progress |
| pins_hiz | output | 1 | Float all I/O pins |
| pins_clamp | output | 1 | Hold I/O pins at clamp_val |
| clamp_val | output | PIN_W | Pin values held during clamping |
| reconfig_pulse | output | 1 | One-cycle reconfiguration request |
| cfg_status_n | output | 1 | Configuration status line, low while held |
| cfg_abort | output | 1 | One-cycle request to stop a running configuration |

## Verification
Two events can land on the same TCK edge. One is the reconfiguration pulse. The other is the release of the status-line hold, since the same edge that starts the pulse must also clear the hold. The bench first leaves the hold set with 0x00D, loads a few other instructions, and then loads 0x001. In the first Run-Test/Idle cycle after that Update-IR it expects reconfig_pulse high and cfg_status_n high together, and in the next cycle it expects the pulse to have dropped while the line stays high. Loading 0x00D with cfg_busy_i high also checks, on a single edge, that the abort pulse and the start of the hold occur together.

// File: rtl/jtag_dev_pkg.sv
package jtag_dev_pkg;

    localparam int IR_W = 10;

    typedef enum logic [3:0] {
        TLR, RTI,
        SEL_DR, CAP_DR, SH_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
        SEL_IR, CAP_IR, SH_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYP,
        SEL_USER,
        SEL_ID
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_PULSE = 10'h001;
    localparam logic [IR_W-1:0] OP_ID    = 10'h006;
    localparam logic [IR_W-1:0] OP_USER  = 10'h007;
    localparam logic [IR_W-1:0] OP_CLAMP = 10'h00A;
    localparam logic [IR_W-1:0] OP_HIZ   = 10'h00B;
    localparam logic [IR_W-1:0] OP_CFGIO = 10'h00D;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        tap_state_e n;
        case (s)
            TLR:     n = m ? TLR    : RTI;
            RTI:     n = m ? SEL_DR : RTI;
            SEL_DR:  n = m ? SEL_IR : CAP_DR;
            CAP_DR:  n = m ? EX1_DR : SH_DR;
            SH_DR:   n = m ? EX1_DR : SH_DR;
            EX1_DR:  n = m ? UPD_DR : PAU_DR;
            PAU_DR:  n = m ? EX2_DR : PAU_DR;
            EX2_DR:  n = m ? UPD_DR : SH_DR;
            UPD_DR:  n = m ? SEL_DR : RTI;
            SEL_IR:  n = m ? TLR    : CAP_IR;
            CAP_IR:  n = m ? EX1_IR : SH_IR;
            SH_IR:   n = m ? EX1_IR : SH_IR;
            EX1_IR:  n = m ? UPD_IR : PAU_IR;
            PAU_IR:  n = m ? EX2_IR : PAU_IR;
            EX2_IR:  n = m ? UPD_IR : SH_IR;
            UPD_IR:  n = m ? SEL_DR : RTI;
            default: n = TLR;
        endcase
        return n;
    endfunction

    function automatic dr_sel_e decode_sel(input logic [IR_W-1:0] op);
        dr_sel_e d;
        case (op)
            OP_USER: d = SEL_USER;
            OP_ID:   d = SEL_ID;
            default: d = SEL_BYP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_dev_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state,
    output tap_state_e nxt
);

    logic [2:0] ones;

    always_comb nxt = tap_next(state, tms);

    always_ff @(posedge tck) begin
        if (rst) state <= TLR;
        else     state <= nxt;
    end

    // run length of TMS-high edges, saturating at five
    always_ff @(posedge tck) begin
        if (rst || !tms)      ones <= 3'd0;
        else if (ones != 3'd5) ones <= 3'(ones + 3'd1);
    end

    assert_five_tms_reset_R11: assert property (@(posedge tck) disable iff (rst)
        (ones == 3'd5) |-> (state == TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_dev_pkg::*;
(
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    output logic [IR_W-1:0] ir_shift,
    output logic [IR_W-1:0] ir_active
);

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_shift  <= '0;
            ir_active <= OP_ID;
        end else begin
            case (state)
                TLR:     ir_active <= OP_ID;
                CAP_IR:  ir_shift  <= IR_W'(2'b01);
                SH_IR:   ir_shift  <= {tdi, ir_shift[IR_W-1:1]};
                UPD_IR:  ir_active <= ir_shift;
                default: ;
            endcase
        end
    end

    assert_ir_capture_R2: assert property (@(posedge tck) disable iff (rst)
        (state == CAP_IR) |=> (ir_shift[1:0] == 2'b01));

    assert_ir_update_only_R13: assert property (@(posedge tck) disable iff (rst)
        (state != UPD_IR && state != TLR) |=> $stable(ir_active));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_dev_pkg::*;
#(
    parameter int              DR_W       = 32,
    parameter logic [DR_W-1:0] IDCODE_VAL = 32'h1A5C_3001
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tdi,
    input  tap_state_e      state,
    input  dr_sel_e         sel,
    input  logic [DR_W-1:0] usercode,
    output logic            dr_lsb
);

    logic [DR_W-1:0] wide_q;
    logic            byp_q;

    always_ff @(posedge tck) begin
        if (rst) begin
            wide_q <= '0;
            byp_q  <= 1'b0;
        end else begin
            case (state)
                CAP_DR: begin
                    byp_q <= 1'b0;
                    case (sel)
                        SEL_USER: wide_q <= usercode;
                        SEL_ID:   wide_q <= IDCODE_VAL;
                        default:  ;
                    endcase
                end
                SH_DR: begin
                    byp_q  <= tdi;
                    wide_q <= {tdi, wide_q[DR_W-1:1]};
                end
                default: ;
            endcase
        end
    end

    always_comb dr_lsb = (sel == SEL_BYP) ? byp_q : wide_q[0];

    assert_bypass_capture_R5: assert property (@(posedge tck) disable iff (rst)
        (state == CAP_DR && sel == SEL_BYP) |=> (dr_lsb == 1'b0));

    assert_id_capture_R4: assert property (@(posedge tck) disable iff (rst)
        (state == CAP_DR && sel == SEL_ID) |=> (dr_lsb == IDCODE_VAL[0]));

endmodule

// File: rtl/tap_ctl.sv
module tap_ctl
    import jtag_dev_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             tck,
    input  logic             rst,
    input  tap_state_e       state,
    input  tap_state_e       nxt,
    input  logic [IR_W-1:0]  ir_active,
    input  logic [IR_W-1:0]  ir_shift,
    input  logic [PIN_W-1:0] bscan_i,
    input  logic             cfg_busy_i,
    output logic             pins_hiz,
    output logic             pins_clamp,
    output logic [PIN_W-1:0] clamp_val,
    output logic             reconfig_pulse,
    output logic             cfg_status_n,
    output logic             cfg_abort
);

    logic [IR_W-1:0] op_eff;
    logic            fire;
    logic            cfgio_upd;
    logic            clamp_upd;
    logic            hold_q;

    // instruction in force after this edge, so Update-IR -> Idle can pulse
    always_comb begin
        op_eff    = (state == UPD_IR) ? ir_shift : ir_active;
        fire      = (nxt == RTI) && (state != RTI) && (op_eff == OP_PULSE);
        cfgio_upd = (state == UPD_IR) && (ir_shift == OP_CFGIO);
        clamp_upd = (state == UPD_IR) && (ir_shift == OP_CLAMP);
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            reconfig_pulse <= 1'b0;
            cfg_abort      <= 1'b0;
            hold_q         <= 1'b0;
            clamp_val      <= '0;
        end else begin
            reconfig_pulse <= fire;
            cfg_abort      <= cfgio_upd && cfg_busy_i;
            if (fire)           hold_q <= 1'b0;
            else if (cfgio_upd) hold_q <= 1'b1;
            if (clamp_upd)      clamp_val <= bscan_i;
        end
    end

    always_comb begin
        pins_hiz     = (ir_active == OP_HIZ);
        pins_clamp   = (ir_active == OP_CLAMP);
        cfg_status_n = !hold_q;
    end

    assert_pulse_single_R8: assert property (@(posedge tck) disable iff (rst)
        reconfig_pulse |=> !reconfig_pulse);

    assert_status_sticky_R9: assert property (@(posedge tck) disable iff (rst)
        !cfg_status_n |=> (!cfg_status_n || reconfig_pulse));

    assert_abort_needs_busy_R10: assert property (@(posedge tck) disable iff (rst)
        cfg_abort |-> $past(cfg_busy_i));

    assert_clamp_held_R7: assert property (@(posedge tck) disable iff (rst)
        (pins_clamp && state != UPD_IR) |=> $stable(clamp_val));

    assert_hiz_clamp_excl_R6: assert property (@(posedge tck) disable iff (rst)
        !(pins_hiz && pins_clamp));

endmodule

// File: rtl/jtag_dev_tap.sv
module jtag_dev_tap
    import jtag_dev_pkg::*;
#(
    parameter int          PIN_W      = 32,
    parameter logic [31:0] IDCODE_VAL = 32'h1A5C_3001
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo,
    output logic             tdo_en,
    input  logic [31:0]      usercode_i,
    input  logic [PIN_W-1:0] bscan_i,
    input  logic             cfg_busy_i,
    output logic             pins_hiz,
    output logic             pins_clamp,
    output logic [PIN_W-1:0] clamp_val,
    output logic             reconfig_pulse,
    output logic             cfg_status_n,
    output logic             cfg_abort
);

    localparam int DR_W = 32;

    logic            rst;
    tap_state_e      state;
    tap_state_e      nxt;
    logic [IR_W-1:0] ir_shift;
    logic [IR_W-1:0] ir_active;
    dr_sel_e         sel;
    logic            dr_lsb;
    logic            tdo_q;
    logic            tdo_en_q;

    always_comb begin
        rst = !trst_n;
        sel = decode_sel(ir_active);
    end

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state),
        .nxt   (nxt)
    );

    tap_ir u_ir (
        .tck       (tck),
        .rst       (rst),
        .tdi       (tdi),
        .state     (state),
        .ir_shift  (ir_shift),
        .ir_active (ir_active)
    );

    tap_dr #(
        .DR_W       (DR_W),
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck      (tck),
        .rst      (rst),
        .tdi      (tdi),
        .state    (state),
        .sel      (sel),
        .usercode (usercode_i),
        .dr_lsb   (dr_lsb)
    );

    tap_ctl #(
        .PIN_W (PIN_W)
    ) u_ctl (
        .tck            (tck),
        .rst            (rst),
        .state          (state),
        .nxt            (nxt),
        .ir_active      (ir_active),
        .ir_shift       (ir_shift),
        .bscan_i        (bscan_i),
        .cfg_busy_i     (cfg_busy_i),
        .pins_hiz       (pins_hiz),
        .pins_clamp     (pins_clamp),
        .clamp_val      (clamp_val),
        .reconfig_pulse (reconfig_pulse),
        .cfg_status_n   (cfg_status_n),
        .cfg_abort      (cfg_abort)
    );

    // serial output is retimed to the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_en_q <= (state == SH_DR) || (state == SH_IR);
            tdo_q    <= (state == SH_IR) ? ir_shift[0] : dr_lsb;
        end
    end

    always_comb begin
        tdo_en = tdo_en_q;
        tdo    = tdo_en_q & tdo_q;
    end

    assert_tdo_en_shift_R12: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (state == SH_DR || state == SH_IR));

    assert_tdo_quiet_R12: assert property (@(posedge tck) disable iff (rst)
        !tdo_en |-> !tdo);

endmodule

// File: tb/jtag_dev_tap_bench.sv
module jtag_dev_tap_bench;

    localparam logic [31:0] IDV = 32'h1A5C_3001;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [31:0] usercode_i = '0;
    logic [31:0] bscan_i = '0;
    logic        cfg_busy_i = 1'b0;
    logic        tdo, tdo_en, pins_hiz, pins_clamp, reconfig_pulse, cfg_status_n, cfg_abort;
    logic [31:0] clamp_val;

    int total = 0;
    int bad = 0;

    jtag_dev_tap #(.PIN_W(32), .IDCODE_VAL(IDV)) u_jtag_dev_tap (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .usercode_i(usercode_i), .bscan_i(bscan_i), .cfg_busy_i(cfg_busy_i),
        .pins_hiz(pins_hiz), .pins_clamp(pins_clamp), .clamp_val(clamp_val),
        .reconfig_pulse(reconfig_pulse), .cfg_status_n(cfg_status_n), .cfg_abort(cfg_abort)
    );

    always #2 tck = ~tck;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clk(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic ir_to_exit(input logic [9:0] code, output logic [9:0] cap);
        clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 10; i++) begin
            cap[i] = tdo;
            if (i == 0) chk("R12 tdo_en in Shift-IR", 64'(tdo_en), 64'd1);
            clk(i == 9, code[i]);
        end
    endtask

    task automatic load_ir(input logic [9:0] code, output logic [9:0] cap);
        ir_to_exit(code, cap);
        clk(1, 0);
        clk(0, 0);
    endtask

    task automatic scan_dr(input logic [32:0] din, output logic [32:0] dout);
        clk(1, 0); clk(0, 0); clk(0, 0);
        for (int i = 0; i < 33; i++) begin
            dout[i] = tdo;
            if (i == 0) chk("R12 tdo_en in Shift-DR", 64'(tdo_en), 64'd1);
            clk(i == 32, din[i]);
        end
        clk(1, 0);
        clk(0, 0);
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (190000) @(posedge tck);
        total++;
        bad++;
        $display("FAIL watchdog R1..all actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [9:0]  cap;
        logic [32:0] din, dout, exp;
        logic        stat_exp;

        @(negedge tck); #1;
        repeat (3) clk(1, 0);
        trst_n = 1'b1;
        chk("R1 hiz after reset", 64'(pins_hiz), 64'd0);
        chk("R1 clamp after reset", 64'(pins_clamp), 64'd0);
        chk("R1 pulse after reset", 64'(reconfig_pulse), 64'd0);
        chk("R1 status after reset", 64'(cfg_status_n), 64'd1);
        chk("R1 abort after reset", 64'(cfg_abort), 64'd0);
        chk("R12 tdo_en idle after reset", 64'(tdo_en), 64'd0);
        clk(0, 0);
        din = 33'h1_0F0F_1234;
        scan_dr(din, dout);
        chk("R1 reset instruction is identification", 64'(dout), 64'({din[0], IDV}));
        chk("R12 tdo_en low in Run-Test/Idle", 64'(tdo_en), 64'd0);
        chk("R12 tdo low when disabled", 64'(tdo), 64'd0);

        // sweep of every instruction code
        stat_exp = 1'b1;
        for (int c = 0; c < 1024; c++) begin
            logic [9:0] code;
            code = 10'(c);
            usercode_i = (32'(c) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
            bscan_i    = ~usercode_i ^ 32'(c << 7);
            load_ir(code, cap);
            chk("R2 captured instruction pattern", 64'(cap), 64'h001);
            chk("R6 hiz follows 0x00B", 64'(pins_hiz), 64'(code == 10'h00B));
            chk("R7 clamp follows 0x00A", 64'(pins_clamp), 64'(code == 10'h00A));
            if (code == 10'h00A) chk("R7 clamp value sampled", 64'(clamp_val), 64'(bscan_i));
            chk("R8 pulse on idle entry", 64'(reconfig_pulse), 64'(code == 10'h001));
            if (code == 10'h00D) stat_exp = 1'b0;
            chk("R9 status line model", 64'(cfg_status_n), 64'(stat_exp));
            chk("R10 no abort when idle config", 64'(cfg_abort), 64'd0);
            din = {code[0], usercode_i ^ 32'hC3C3_3C3C};
            scan_dr(din, dout);
            if (code == 10'h007) begin
                exp = {din[0], usercode_i};
                chk("R3 user code scan", 64'(dout), 64'(exp));
            end else if (code == 10'h006) begin
                exp = {din[0], IDV};
                chk("R4 identification scan", 64'(dout), 64'(exp));
            end else begin
                exp = {din[31:0], 1'b0};
                chk("R5 bypass scan", 64'(dout), 64'(exp));
            end
        end

        // sticky status line and its release by reconfiguration
        load_ir(10'h006, cap);
        chk("R9 status held across other instruction", 64'(cfg_status_n), 64'd0);
        load_ir(10'h001, cap);
        chk("R8 pulse with release", 64'(reconfig_pulse), 64'd1);
        chk("R9 status released by pulse", 64'(cfg_status_n), 64'd1);
        clk(0, 0);
        chk("R8 pulse lasts one cycle", 64'(reconfig_pulse), 64'd0);
        chk("R9 status stays released", 64'(cfg_status_n), 64'd1);
        scan_dr(33'h0, dout);
        chk("R8 pulse on re-entry", 64'(reconfig_pulse), 64'd1);
        clk(0, 0);
        chk("R8 no pulse while staying idle", 64'(reconfig_pulse), 64'd0);

        // configuration abort
        cfg_busy_i = 1'b1;
        load_ir(10'h00D, cap);
        chk("R10 abort while busy", 64'(cfg_abort), 64'd1);
        chk("R9 status low with abort", 64'(cfg_status_n), 64'd0);
        clk(0, 0);
        chk("R10 abort single cycle", 64'(cfg_abort), 64'd0);
        cfg_busy_i = 1'b0;
        load_ir(10'h00D, cap);
        chk("R10 no abort when not busy", 64'(cfg_abort), 64'd0);

        // update timing
        ir_to_exit(10'h00B, cap);
        chk("R13 hiz not yet at Exit1-IR", 64'(pins_hiz), 64'd0);
        clk(1, 0);
        chk("R13 hiz not yet in Update-IR", 64'(pins_hiz), 64'd0);
        clk(0, 0);
        chk("R13 hiz after update edge", 64'(pins_hiz), 64'd1);

        // clamp value hold
        bscan_i = 32'hDEAD_BEEF;
        load_ir(10'h00A, cap);
        bscan_i = 32'h1357_9BDF;
        clk(0, 0); clk(0, 0);
        chk("R7 clamp value held", 64'(clamp_val), 64'hDEAD_BEEF);
        scan_dr(33'h1_FFFF_FFFE, dout);
        chk("R7 clamp value held over scan", 64'(clamp_val), 64'hDEAD_BEEF);

        // TMS reset
        load_ir(10'h00B, cap);
        repeat (5) clk(1, 0);
        chk("R11 hiz cleared by TMS reset", 64'(pins_hiz), 64'd0);
        clk(0, 0);
        din = 33'h0_A5A5_5A5A;
        scan_dr(din, dout);
        chk("R11 identification after TMS reset", 64'(dout), 64'({din[0], IDV}));

        // trst_n mid-run
        load_ir(10'h00B, cap);
        trst_n = 1'b0;
        clk(0, 0);
        trst_n = 1'b1;
        chk("R1 trst clears hiz", 64'(pins_hiz), 64'd0);
        chk("R1 trst status high", 64'(cfg_status_n), 64'd1);

        summary();
        $finish;
    end

endmodule